// File: doc/BRIEF.md
# Packed Integer Dot-Product Accumulator

This block computes a short integer dot product between two packed words and adds it to a running accumulator. Each operand word is split into narrow lanes. Each pair of matching lanes is multiplied, and the products are added to a full-width accumulator input. The lanes can be four 8-bit elements or eight 4-bit elements, and they can be read as signed or unsigned. The block is meant to sit inside a quantized inference datapath, where a compute lane issues one operation per cycle and gets the result back on the next cycle.

Each operation carries its own clamp flag. With the flag clear, a sum that leaves the 32-bit range wraps around. With the flag set, the result sticks at the nearest end of the signed or unsigned range. The exact sum is formed on a wider internal path, so the overflow decision is made before any truncation.

There is no handshake. Each cycle with the input valid high produces one registered result one cycle later, and the output valid marks it.

Top module: `pkdot_acc_unit`

## Requirements
- R1: When `in_mode[1]` is 0, each operand holds four 8-bit elements. Element i sits in bits [8i+7:8i], and the four pairwise products are added to the accumulator.
- R2: When `in_mode[1]` is 1, each operand holds eight 4-bit elements. Element i sits in bits [4i+3:4i], and the eight pairwise products are added to the accumulator.
- R3: When `in_mode[0]` is 0, the elements and the accumulator are two's complement and are sign-extended. When `in_mode[0]` is 1, they are unsigned and are zero-extended. The four modes are 00 signed 8-bit, 01 unsigned 8-bit, 10 signed 4-bit and 11 unsigned 4-bit.
- R4: With `in_clamp` at 0, the result is the exact sum taken modulo 2^32.
- R5: In a signed mode with `in_clamp` at 1, an exact sum above 2^31-1 gives 0x7FFFFFFF.
- R6: In a signed mode with `in_clamp` at 1, an exact sum below -2^31 gives 0x80000000.
- R7: In an unsigned mode with `in_clamp` at 1, an exact sum above 2^32-1 gives 0xFFFFFFFF.
- R8: With `in_clamp` at 1 and the exact sum inside the range of the mode, the result equals the exact sum, including the range end points.
- R9: `res_q` and `res_vld` take the result of an operation at the first rising edge after `in_vld` is sampled high, and back-to-back operations are accepted every cycle. Synchronous reset clears `res_vld` and `res_q` to zero.
- R10: A cycle with `in_vld` low leaves `res_q` unchanged and drives `res_vld` low, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operation issue strobe |
| in_mode | input | 2 | Bit 1: lane width (0 = 8-bit, 1 = 4-bit); bit 0: 1 = unsigned |
| in_clamp | input | 1 | 1 = saturate on overflow, 0 = wrap |
| in_a | input | 32 | First packed operand |
| in_b | input | 32 | Second packed operand |
| in_acc | input | 32 | Accumulator addend |
| res_vld | output | 1 | Result valid, one cycle after issue |
| res_q | output | 32 | Registered result |

## Verification
Every internal fault shows up at `res_q` on the cycle right after the issuing strobe. There is no other state in the block, so a wrong lane slice, a wrong extension or a wrong saturation choice gives a wrong word at once and cannot hide for later cycles. The sweeps drive all pairs of 4-bit values in every lane position, and every 8-bit value against a spread of partners, in all four modes with both clamp settings. Hand-picked cases then sit on and just past each range boundary, which catches an off-by-one in the overflow test. A fault in the valid path or the hold path shows up as a wrong `res_vld` or a changed `res_q` in the idle cycles that follow an operation.

// File: rtl/pkdot_pkg.sv
package pkdot_pkg;

   // bit 1 picks the lane width, bit 0 picks unsigned interpretation
   typedef enum logic [1:0] {
      PK_S8 = 2'b00,
      PK_U8 = 2'b01,
      PK_S4 = 2'b10,
      PK_U4 = 2'b11
   } pk_mode_e;

   localparam int PK_GUARD = 8;   // extra sum bits above the data width

endpackage

// File: rtl/pkdot_lanes.sv
module pkdot_lanes #(
   parameter int DW   = 32,
   parameter int LW   = 8,
   parameter int SUMW = 40
) (
   input  logic                   uns,
   input  logic [DW-1:0]          a,
   input  logic [DW-1:0]          b,
   output logic signed [SUMW-1:0] psum
);
   localparam int NL = DW / LW;
   localparam int EW = LW + 1;
   localparam int PW = 2 * EW;

   if (DW % LW != 0) begin : g_bad_lw
      $error("pkdot_lanes: DW must be a multiple of LW");
   end
   if (SUMW < PW + $clog2(NL + 1)) begin : g_bad_sumw
      $error("pkdot_lanes: SUMW too narrow for product sum");
   end

   logic signed [PW-1:0] prod [NL];

   for (genvar i = 0; i < NL; i++) begin : g_lane
      logic signed [EW-1:0] ea, eb;
      assign ea = {~uns & a[i*LW+LW-1], a[i*LW +: LW]};
      assign eb = {~uns & b[i*LW+LW-1], b[i*LW +: LW]};
      assign prod[i] = PW'(ea) * PW'(eb);
   end

   always_comb begin
      psum = '0;
      for (int i = 0; i < NL; i++) begin
         psum = psum + SUMW'(prod[i]);
      end
   end

endmodule

// File: rtl/pkdot_sat.sv
module pkdot_sat #(
   parameter int DW   = 32,
   parameter int SUMW = 40
) (
   input  logic signed [SUMW-1:0] exact,
   input  logic                   uns,
   input  logic                   clamp,
   output logic [DW-1:0]          res
);
   localparam logic signed [SUMW-1:0] SMAX = {{(SUMW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [SUMW-1:0] SMIN = {{(SUMW-DW+1){1'b1}}, {(DW-1){1'b0}}};
   localparam logic signed [SUMW-1:0] UMAX = {{(SUMW-DW){1'b0}}, {DW{1'b1}}};
   localparam logic [DW-1:0] S_HI = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] S_LO = {1'b1, {(DW-1){1'b0}}};
   localparam logic [DW-1:0] U_HI = {DW{1'b1}};

   if (SUMW <= DW) begin : g_bad_sumw
      $error("pkdot_sat: SUMW must exceed DW");
   end

   always_comb begin
      res = exact[DW-1:0];
      if (clamp) begin
         if (uns) begin
            if (exact > UMAX) res = U_HI;
         end else begin
            if (exact > SMAX)      res = S_HI;
            else if (exact < SMIN) res = S_LO;
         end
      end
   end

endmodule

// File: rtl/pkdot_acc_unit.sv
module pkdot_acc_unit #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_vld,
   input  logic [1:0]    in_mode,
   input  logic          in_clamp,
   input  logic [DW-1:0] in_a,
   input  logic [DW-1:0] in_b,
   input  logic [DW-1:0] in_acc,
   output logic          res_vld,
   output logic [DW-1:0] res_q
);
   import pkdot_pkg::*;

   localparam int SUMW = DW + PK_GUARD;
   localparam int NW   = 2;              // number of lane-width variants
   localparam int LWS [NW] = '{8, 4};

   if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
      $error("pkdot_acc_unit: DW must be a positive multiple of 8");
   end

   logic                   uns;
   logic signed [SUMW-1:0] psum [NW];
   logic signed [SUMW-1:0] acc_x;
   logic signed [SUMW-1:0] exact;
   logic [DW-1:0]          sat_res;

   assign uns = in_mode[0];

   for (genvar w = 0; w < NW; w++) begin : g_width
      pkdot_lanes #(.DW(DW), .LW(LWS[w]), .SUMW(SUMW)) u_lanes (
         .uns  (uns),
         .a    (in_a),
         .b    (in_b),
         .psum (psum[w])
      );
   end

   assign acc_x = {{(SUMW-DW){~uns & in_acc[DW-1]}}, in_acc};
   assign exact = acc_x + psum[in_mode[1]];

   pkdot_sat #(.DW(DW), .SUMW(SUMW)) u_sat (
      .exact (exact),
      .uns   (uns),
      .clamp (in_clamp),
      .res   (sat_res)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         res_vld <= 1'b0;
         res_q   <= '0;
      end else begin
         res_vld <= in_vld;
         if (in_vld) res_q <= sat_res;
      end
   end

   // overflow flags written from the top bits of the exact sum
   logic ovf_spos, ovf_sneg, ovf_u, in_range_s;
   assign ovf_spos   = !exact[SUMW-1] && (|exact[SUMW-1:DW-1]);
   assign ovf_sneg   = exact[SUMW-1] && !(&exact[SUMW-1:DW-1]);
   assign ovf_u      = |exact[SUMW-1:DW];
   assign in_range_s = (&exact[SUMW-1:DW-1]) || !(|exact[SUMW-1:DW-1]);

   // R9: an issue shows a valid result on the next edge
   a_r9_vld_next: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> res_vld);
   // R9: the output valid never rises without an issue the cycle before
   a_r9_vld_src: assert property (@(posedge clk) disable iff (rst)
      res_vld |-> $past(in_vld));
   // R10: an idle cycle holds the result
   a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> $stable(res_q));
   // R4: wrap mode keeps the low word of the exact sum
   a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
      in_vld && !in_clamp |=> res_q == $past(exact[DW-1:0]));
   // R5: signed positive saturation
   a_r5_pos_sat: assert property (@(posedge clk) disable iff (rst)
      in_vld && in_clamp && !in_mode[0] && ovf_spos |=> res_q == {1'b0, {(DW-1){1'b1}}});
   // R6: signed negative saturation
   a_r6_neg_sat: assert property (@(posedge clk) disable iff (rst)
      in_vld && in_clamp && !in_mode[0] && ovf_sneg |=> res_q == {1'b1, {(DW-1){1'b0}}});
   // R7: unsigned saturation
   a_r7_uns_sat: assert property (@(posedge clk) disable iff (rst)
      in_vld && in_clamp && in_mode[0] && ovf_u |=> res_q == {DW{1'b1}});
   // R8: signed in-range sum passes through untouched under clamp
   a_r8_in_range: assert property (@(posedge clk) disable iff (rst)
      in_vld && in_clamp && !in_mode[0] && in_range_s |=> res_q == $past(exact[DW-1:0]));

endmodule

// File: tb/pkdot_acc_unit_test.sv
module pkdot_acc_unit_test;

   logic        clk = 1'b0;
   logic        rst;
   logic        in_vld;
   logic [1:0]  in_mode;
   logic        in_clamp;
   logic [31:0] in_a, in_b, in_acc;
   logic        res_vld;
   logic [31:0] res_q;

   int checks   = 0;
   int failures = 0;
   int cyc      = 0;
   bit done     = 0;

   always #4 clk = ~clk;   // 125 MHz

   pkdot_acc_unit #(.DW(32)) uut (
      .clk(clk), .rst(rst), .in_vld(in_vld), .in_mode(in_mode),
      .in_clamp(in_clamp), .in_a(in_a), .in_b(in_b), .in_acc(in_acc),
      .res_vld(res_vld), .res_q(res_q)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         failures++;
         $display("FAIL watchdog expired: actual cycles=%0d expected <= 150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   function automatic logic [31:0] ref_dot(logic [1:0] m, logic c,
                                           logic [31:0] a, logic [31:0] b,
                                           logic [31:0] acc);
      longint s, ea, eb, full, half;
      int lw, n;
      lw   = m[1] ? 4 : 8;
      n    = 32 / lw;
      full = longint'(1) << lw;
      half = full >> 1;
      s = m[0] ? longint'(acc) : longint'($signed(acc));
      for (int i = 0; i < n; i++) begin
         ea = longint'((a >> (i * lw))) & (full - 1);
         eb = longint'((b >> (i * lw))) & (full - 1);
         if (!m[0] && ea >= half) ea = ea - full;
         if (!m[0] && eb >= half) eb = eb - full;
         s = s + ea * eb;
      end
      if (c) begin
         if (!m[0]) begin
            if (s > 64'sh7fffffff) return 32'h7fffffff;
            if (s < -64'sh80000000) return 32'h80000000;
         end else if (s > 64'shffffffff) begin
            return 32'hffffffff;
         end
      end
      return s[31:0];
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   // called at a falling edge; leaves the call at the next falling edge
   task automatic do_op(logic [1:0] m, logic c, logic [31:0] a, logic [31:0] b,
                        logic [31:0] acc, string tag);
      logic [31:0] exp;
      exp      = ref_dot(m, c, a, b, acc);
      in_vld   = 1'b1;
      in_mode  = m;
      in_clamp = c;
      in_a     = a;
      in_b     = b;
      in_acc   = acc;
      @(negedge clk);
      check(res_vld === 1'b1, {tag, " R9 valid"}, {31'b0, res_vld}, 32'h1);
      check(res_q === exp, tag, res_q, exp);
   endtask

   initial begin
      rst = 1'b1; in_vld = 1'b0; in_mode = 2'b00; in_clamp = 1'b0;
      in_a = '0; in_b = '0; in_acc = '0;
      repeat (4) @(negedge clk);
      // R9: reset state
      check(res_vld === 1'b0, "R9 reset valid", {31'b0, res_vld}, 32'h0);
      check(res_q === 32'h0, "R9 reset result", res_q, 32'h0);
      rst = 1'b0;
      @(negedge clk);

      // R1 R2 R3 R4 R8: sweeps across all four modes, issued back to back
      for (int m = 0; m < 4; m++) begin
         for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y += 17) begin
               logic [7:0]  xb, yb;
               logic [31:0] acc;
               xb  = 8'(x);
               yb  = 8'(y);
               acc = 32'(x * 40503 + y * 977) ^ {xb, yb, ~xb, yb};
               do_op(2'(m), xb[0], {4{xb}}, {yb, ~yb, yb ^ 8'h3c, yb},
                     acc, m[1] ? "R2/R3 sweep" : "R1/R3 sweep");
            end
         end
      end

      // R4: wrap on signed positive overflow
      do_op(2'b00, 1'b0, 32'h01010101, 32'h01010101, 32'h7fffffff, "R4 wrap pos");
      check(res_q === 32'h80000003, "R4 wrap value", res_q, 32'h80000003);
      // R5: the same sum saturates
      do_op(2'b00, 1'b1, 32'h01010101, 32'h01010101, 32'h7fffffff, "R5 pos sat");
      check(res_q === 32'h7fffffff, "R5 pos value", res_q, 32'h7fffffff);
      // R6: negative overflow, 8-bit then 4-bit
      do_op(2'b00, 1'b1, 32'h7f7f7f7f, 32'h80808080, 32'h80000000, "R6 neg sat s8");
      check(res_q === 32'h80000000, "R6 neg value", res_q, 32'h80000000);
      do_op(2'b00, 1'b0, 32'h7f7f7f7f, 32'h80808080, 32'h80000000, "R4 wrap neg");
      do_op(2'b10, 1'b1, 32'h11111111, 32'hffffffff, 32'h80000000, "R6 neg sat s4");
      // R7: unsigned overflow, 8-bit and 4-bit
      do_op(2'b01, 1'b1, 32'hffffffff, 32'hffffffff, 32'hffffffff, "R7 sat u8");
      check(res_q === 32'hffffffff, "R7 u8 value", res_q, 32'hffffffff);
      do_op(2'b01, 1'b0, 32'hffffffff, 32'hffffffff, 32'hffffffff, "R4 wrap u8");
      do_op(2'b11, 1'b1, 32'hffffffff, 32'hffffffff, 32'hfffffff0, "R7 sat u4");
      // R8: clamp on, sums on the range end points are not altered
      do_op(2'b00, 1'b1, 32'h00000001, 32'h00000001, 32'h7ffffffe, "R8 at smax");
      check(res_q === 32'h7fffffff, "R8 smax value", res_q, 32'h7fffffff);
      do_op(2'b00, 1'b1, 32'h000000ff, 32'h00000001, 32'h80000001, "R8 at smin");
      check(res_q === 32'h80000000, "R8 smin value", res_q, 32'h80000000);
      do_op(2'b01, 1'b1, 32'h00000001, 32'h00000001, 32'hfffffffe, "R8 at umax");
      do_op(2'b10, 1'b1, 32'h00000007, 32'h00000008, 32'h00000010, "R8 s4 mixed");
      check(res_q === 32'hffffffd8, "R8 s4 value", res_q, 32'hffffffd8);

      // R10: idle cycles with changing inputs leave the result alone
      do_op(2'b01, 1'b0, 32'h01020304, 32'h05060708, 32'h00000100, "R1 u8 known");
      check(res_q === 32'h00000146, "R1 u8 value", res_q, 32'h00000146);
      in_vld = 1'b0;
      for (int k = 0; k < 3; k++) begin
         in_a = 32'hdeadbeef ^ 32'(k); in_b = 32'h12345678; in_acc = 32'(k * 99);
         in_mode = 2'(k); in_clamp = k[0];
         @(negedge clk);
         check(res_vld === 1'b0, "R10 valid low", {31'b0, res_vld}, 32'h0);
         check(res_q === 32'h00000146, "R10 hold", res_q, 32'h00000146);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule